// File: doc/BRIEF.md
# Page Program Buffer with In-Page Wraparound

This block gathers the data bytes of one page-program command for a 256-byte flash page and then writes them into the array. The serial front end first pulses `cmd_start` with the target address. It then streams data bytes over a valid/ready interface and ends the command with a pulse on `cmd_end`. Alongside that pulse it says whether chip select rose exactly on a byte boundary. The low address bits select the starting offset inside the page, and the offset advances one step per byte and wraps inside the same page. A long command therefore leaves the most recent 256 bytes in the buffer. A per-offset mask records which offsets received data, and only those offsets reach the array.

When the command ends cleanly, the block checks three things: at least one byte arrived, the write-enable latch (`wel_in`) is set, and the external protection logic grants permission (`page_ok`). If all three hold, it starts a self-timed program cycle of `CYCLE_LEN` clocks. During the cycle it raises `wip`, pulses `wel_clr` once, and sweeps the page. For each marked offset it reads the old array byte and writes back the old byte ANDed with the new data, since programming can only clear bits. An erased array byte reads FFh. Any failed condition drops the command without a trace.

Stream rules: `in_ready` is high only while a command is collecting bytes, and is forced low in any cycle where `cmd_end` is high. A byte is taken on a clock edge where both `in_valid` and `in_ready` are high. The sender may hold `in_valid` low for any number of cycles between bytes.

Top module: `pgm_page_buffer`

## Requirements
- R1: After reset, `wip`, `wel_clr`, `in_ready`, `arr_rd_en` and `arr_wr_en` are all 0.
- R2: `in_ready` is 1 only between an accepted `cmd_start` (taken while idle) and the `cmd_end` pulse, and is 0 in the cycle `cmd_end` is high. A `cmd_end` that arrives while idle has no effect.
- R3: The k-th accepted byte (k from 0) lands at in-page offset (start_addr[7:0] + k) mod 256, and every array access uses page start_addr[ADDR_W-1:8].
- R4: When more than 256 bytes are sent, the byte sent last to an offset is the one that gets programmed.
- R5: Only offsets that received a byte in the current command are written, each exactly once. The mask is cleared at every `cmd_start`.
- R6: Each committed byte equals the old array byte AND the buffered byte. The array read happens one cycle before the write.
- R7: If `end_aligned` is 0 at `cmd_end`, nothing is written, `wel_clr` does not pulse and `wip` stays 0.
- R8: If `wel_in` or `page_ok` is 0, or no byte was accepted, in the `cmd_end` cycle, nothing is written, `wel_clr` does not pulse and `wip` stays 0.
- R9: An accepted command raises `wip` on the edge that samples `cmd_end`. `wip` stays high for exactly `CYCLE_LEN` cycles, and every array write happens while `wip` is 1.
- R10: `wel_clr` is a single-cycle pulse in the first cycle of `wip`.
- R11: `cmd_start` while `wip` is 1 is ignored: `in_ready` stays 0 during and after the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Program command begins (pulse) |
| start_addr | input | ADDR_W | Byte address given with the command |
| in_valid | input | 1 | Data byte valid |
| in_data | input | 8 | Data byte |
| in_ready | output | 1 | Block can take a data byte |
| cmd_end | input | 1 | Chip select rose (pulse) |
| end_aligned | input | 1 | Command ended on a byte boundary |
| wel_in | input | 1 | Current write-enable latch value |
| page_ok | input | 1 | Target page is not protected |
| wip | output | 1 | Program cycle in progress |
| wel_clr | output | 1 | Request to clear the write-enable latch (pulse) |
| arr_addr | output | ADDR_W | Array byte address |
| arr_rd_en | output | 1 | Array read strobe, data returned next cycle |
| arr_rdata | input | 8 | Array read data |
| arr_wr_en | output | 1 | Array write strobe |
| arr_wdata | output | 8 | Array write data |

## Verification
The bench builds the block with the default page of 256 bytes and 17 address bits, and with `CYCLE_LEN` of 540. That length is just above the worst-case sweep of a fully marked page (two cycles per offset), so an exact `wip` width check also confirms that a full-page commit fits in the cycle. Because the page is a full 256 bytes, a 300-byte stream reaches past the wrap point and overwrites earlier offsets. Starting at offset FEh wraps after two bytes. One test page sits at the top of the address space, which exposes any slip in the page bits. Repeat commands on the same page make the AND-with-old-value rule visible.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_BUSY
  } pgm_state_e;
endpackage

// File: rtl/pgm_fill_store.sv
// Page staging storage: data bytes, written-offset mask and the wrapping offset.
module pgm_fill_store #(
  parameter int PAGE_BYTES = 256,
  parameter int OFF_W      = $clog2(PAGE_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  begin_cmd,
  input  logic [OFF_W-1:0]      start_off,
  input  logic                  push,
  input  logic [7:0]            push_data,
  input  logic [OFF_W-1:0]      rd_idx,
  output logic [PAGE_BYTES-1:0] mask,
  output logic                  have_byte,
  output logic [7:0]            rd_byte
);
  logic [7:0]       store [PAGE_BYTES];
  logic [OFF_W-1:0] wr_off;

  // Offset wraps inside the page because its width equals the page index width.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_off    <= '0;
      mask      <= '0;
      have_byte <= 1'b0;
    end else if (begin_cmd) begin
      wr_off    <= start_off;
      mask      <= '0;
      have_byte <= 1'b0;
    end else if (push) begin
      wr_off         <= wr_off + 1'b1;
      mask[wr_off]   <= 1'b1;
      have_byte      <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wr_off] <= push_data;
  end

  assign rd_byte = store[rd_idx];

  assert_push_marks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> have_byte);
  assert_start_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    begin_cmd |=> (mask == '0));
endmodule

// File: rtl/pgm_commit_sweep.sv
// Walks every page offset; marked offsets get a read then an AND-merged write.
module pgm_commit_sweep #(
  parameter int PAGE_BYTES = 256,
  parameter int OFF_W      = $clog2(PAGE_BYTES),
  parameter int ADDR_W     = 17,
  localparam int PG_W      = ADDR_W - OFF_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  input  logic [PG_W-1:0]       page_base,
  input  logic [PAGE_BYTES-1:0] mask,
  input  logic [7:0]            buf_byte,
  input  logic [7:0]            arr_rdata,
  output logic [OFF_W-1:0]      sweep_idx,
  output logic [ADDR_W-1:0]     arr_addr,
  output logic                  arr_rd_en,
  output logic                  arr_wr_en,
  output logic [7:0]            arr_wdata,
  output logic                  done
);
  logic run, phase;
  logic last;

  assign last = (sweep_idx == OFF_W'(PAGE_BYTES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run       <= 1'b0;
      phase     <= 1'b0;
      sweep_idx <= '0;
      done      <= 1'b1;
    end else if (go) begin
      run       <= 1'b1;
      phase     <= 1'b0;
      sweep_idx <= '0;
      done      <= 1'b0;
    end else if (run) begin
      if (!phase && mask[sweep_idx]) begin
        phase <= 1'b1;
      end else begin
        phase <= 1'b0;
        if (last) begin
          run  <= 1'b0;
          done <= 1'b1;
        end else begin
          sweep_idx <= sweep_idx + 1'b1;
        end
      end
    end
  end

  assign arr_addr  = {page_base, sweep_idx};
  assign arr_rd_en = run && !phase && mask[sweep_idx];
  assign arr_wr_en = run && phase;
  assign arr_wdata = arr_rdata & buf_byte;

  assert_wr_marked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_en |-> mask[sweep_idx]);
  assert_rd_before_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_en |-> $past(arr_rd_en));
  assert_access_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_wr_en && arr_rd_en));
endmodule

// File: rtl/pgm_page_buffer.sv
module pgm_page_buffer #(
  parameter int ADDR_W     = 17,
  parameter int PAGE_BYTES = 256,
  parameter int CYCLE_LEN  = 600,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PG_W      = ADDR_W - OFF_W,
  localparam int CNT_W     = $clog2(CYCLE_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  input  logic              cmd_end,
  input  logic              end_aligned,
  input  logic              wel_in,
  input  logic              page_ok,
  output logic              wip,
  output logic              wel_clr,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              arr_rd_en,
  input  logic [7:0]        arr_rdata,
  output logic              arr_wr_en,
  output logic [7:0]        arr_wdata
);
  import pgm_pkg::*;

  pgm_state_e             state;
  logic [PG_W-1:0]        page_q;
  logic [CNT_W-1:0]       cnt;
  logic [PAGE_BYTES-1:0]  mask;
  logic                   have_byte, commit_done, accept, begin_cmd, push, go;
  logic [OFF_W-1:0]       sweep_idx;
  logic [7:0]             buf_byte;

  assign begin_cmd = (state == ST_IDLE) && cmd_start;
  assign in_ready  = (state == ST_FILL) && !cmd_end;
  assign push      = in_valid && in_ready;
  assign accept    = end_aligned && wel_in && page_ok && have_byte;
  assign go        = (state == ST_FILL) && cmd_end && accept;
  assign wip       = (state == ST_BUSY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      page_q  <= '0;
      cnt     <= '0;
      wel_clr <= 1'b0;
    end else begin
      wel_clr <= 1'b0;
      unique case (state)
        ST_IDLE: if (cmd_start) begin
          state  <= ST_FILL;
          page_q <= start_addr[ADDR_W-1:OFF_W];
        end
        ST_FILL: if (cmd_end) begin
          if (accept) begin
            state   <= ST_BUSY;
            cnt     <= '0;
            wel_clr <= 1'b1;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_BUSY: begin
          if (cnt == CNT_W'(CYCLE_LEN - 1)) begin
            if (commit_done) state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  pgm_fill_store #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W)) fill_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .begin_cmd (begin_cmd),
    .start_off (start_addr[OFF_W-1:0]),
    .push      (push),
    .push_data (in_data),
    .rd_idx    (sweep_idx),
    .mask      (mask),
    .have_byte (have_byte),
    .rd_byte   (buf_byte)
  );

  pgm_commit_sweep #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) sweep_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .page_base (page_q),
    .mask      (mask),
    .buf_byte  (buf_byte),
    .arr_rdata (arr_rdata),
    .sweep_idx (sweep_idx),
    .arr_addr  (arr_addr),
    .arr_rd_en (arr_rd_en),
    .arr_wr_en (arr_wr_en),
    .arr_wdata (arr_wdata),
    .done      (commit_done)
  );

  assert_wr_inside_wip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_en |-> wip);
  assert_sweep_done_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> commit_done);
  assert_wel_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !wel_clr);
  assert_wel_at_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> wel_clr);
  assert_ready_not_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !wip);
  assert_start_ignored_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && cmd_start) |=> !in_ready);
endmodule

// File: tb/pgm_page_buffer_tb_top.sv
module pgm_page_buffer_tb_top;
  localparam int AW = 17;
  localparam int PB = 256;
  localparam int CL = 540;

  typedef struct packed {
    logic       pg;
    logic [7:0] off;
    logic [9:0] cnt;
    logic [7:0] seed;
    logic       aligned;
    logic       wel;
    logic       ok;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 10'd4,   8'hA5, 1'b1, 1'b1, 1'b1},
    '{1'b0, 8'hFE, 10'd5,   8'h3C, 1'b1, 1'b1, 1'b1},
    '{1'b1, 8'h10, 10'd300, 8'h81, 1'b1, 1'b1, 1'b1},
    '{1'b0, 8'h00, 10'd256, 8'hF0, 1'b1, 1'b1, 1'b1},
    '{1'b1, 8'h80, 10'd3,   8'h12, 1'b0, 1'b1, 1'b1},
    '{1'b1, 8'h20, 10'd3,   8'h00, 1'b1, 1'b0, 1'b1},
    '{1'b1, 8'h20, 10'd3,   8'h00, 1'b1, 1'b1, 1'b0},
    '{1'b0, 8'h40, 10'd0,   8'h00, 1'b1, 1'b1, 1'b1},
    '{1'b0, 8'h40, 10'd1,   8'h0F, 1'b1, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 1'b0, in_valid = 1'b0, cmd_end = 1'b0;
  logic end_aligned = 1'b0, wel_in = 1'b0, page_ok = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [7:0] in_data = '0;
  logic in_ready, wip, wel_clr, arr_rd_en, arr_wr_en;
  logic [AW-1:0] arr_addr;
  logic [7:0] arr_rdata, arr_wdata;

  int checks = 0;
  int failures = 0;
  int wr_total = 0;
  int bad_addr = 0;
  logic [7:0] mem [512];
  logic [7:0] expm [512];

  always #2.5 clk = ~clk;

  pgm_page_buffer #(.ADDR_W(AW), .PAGE_BYTES(PB), .CYCLE_LEN(CL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .start_addr(start_addr),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .cmd_end(cmd_end), .end_aligned(end_aligned), .wel_in(wel_in), .page_ok(page_ok),
    .wip(wip), .wel_clr(wel_clr), .arr_addr(arr_addr), .arr_rd_en(arr_rd_en),
    .arr_rdata(arr_rdata), .arr_wr_en(arr_wr_en), .arr_wdata(arr_wdata)
  );

  // Behavioural array: two test pages (0x00000 and 0x1FF00), erased to FFh.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) mem[i] <= 8'hFF;
      arr_rdata <= 8'h00;
    end else begin
      if (arr_rd_en) arr_rdata <= mem[{arr_addr[16], arr_addr[7:0]}];
      if (arr_wr_en) begin
        mem[{arr_addr[16], arr_addr[7:0]}] <= arr_wdata;
        wr_total <= wr_total + 1;
      end
      if ((arr_wr_en || arr_rd_en) && (arr_addr[15:8] != {8{arr_addr[16]}}))
        bad_addr <= bad_addr + 1;
    end
  end

  task automatic check(input bit good, input string req, input int act, input int expv);
    checks++;
    if (!good) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [7:0] dbyte(input logic [7:0] seed, input int k);
    return seed + 8'(13 * k) + 8'((k >> 8) * 8'h55);
  endfunction

  task automatic run_vec(input vec_t v);
    logic [7:0] nb [PB];
    bit mark [PB];
    int distinct, wr0, wipc, welc, mism;
    bit commit;
    logic [AW-1:0] base;
    base = v.pg ? 17'h1FF00 : 17'h00000;
    for (int i = 0; i < PB; i++) begin mark[i] = 1'b0; nb[i] = 8'h00; end
    wel_in = v.wel; page_ok = v.ok;
    @(negedge clk);
    cmd_start = 1'b1; start_addr = base | AW'(v.off);
    @(negedge clk);
    cmd_start = 1'b0;
    for (int k = 0; k < int'(v.cnt); k++) begin
      if (k % 3 == 2) @(negedge clk);
      in_valid = 1'b1; in_data = dbyte(v.seed, k);
      nb[(int'(v.off) + k) % PB] = in_data;
      mark[(int'(v.off) + k) % PB] = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
    end
    wr0 = wr_total;
    cmd_end = 1'b1; end_aligned = v.aligned;
    #0.1;
    check(in_ready == 1'b0, "R2 ready low at end", int'(in_ready), 0);
    @(negedge clk);
    cmd_end = 1'b0;
    commit = v.aligned && v.wel && v.ok && (v.cnt != 0);
    distinct = 0;
    for (int i = 0; i < PB; i++) if (mark[i]) distinct++;
    wipc = 0; welc = 0;
    for (int c = 0; c < CL + 20; c++) begin
      if (wip) wipc++;
      if (wel_clr) welc++;
      @(negedge clk);
    end
    if (commit)
      for (int i = 0; i < PB; i++)
        if (mark[i]) expm[{v.pg, 8'(i)}] = expm[{v.pg, 8'(i)}] & nb[i];
    check(wipc == (commit ? CL : 0), commit ? "R9 wip width" : (v.aligned ? "R8 wip" : "R7 wip"),
          wipc, commit ? CL : 0);
    check(welc == (commit ? 1 : 0), commit ? "R10 wel pulse" : (v.aligned ? "R8 wel" : "R7 wel"),
          welc, commit ? 1 : 0);
    check((wr_total - wr0) == (commit ? distinct : 0), "R5 write count",
          wr_total - wr0, commit ? distinct : 0);
    mism = 0;
    for (int i = 0; i < 512; i++) if (mem[i] !== expm[i]) mism++;
    check(mism == 0, v.cnt > 256 ? "R4 page contents" : "R3 R6 page contents", mism, 0);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) expm[i] = 8'hFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(wip == 1'b0, "R1 wip", int'(wip), 0);
    check(wel_clr == 1'b0, "R1 wel_clr", int'(wel_clr), 0);
    check(in_ready == 1'b0, "R1 in_ready", int'(in_ready), 0);
    check(!arr_rd_en && !arr_wr_en, "R1 array strobes", int'(arr_rd_en | arr_wr_en), 0);

    // R2: cmd_end while idle does nothing
    wel_in = 1'b1; page_ok = 1'b1; end_aligned = 1'b1; cmd_end = 1'b1;
    @(negedge clk);
    cmd_end = 1'b0;
    repeat (3) @(negedge clk);
    check(!wip && !in_ready, "R2 idle end ignored", int'(wip | in_ready), 0);

    foreach (VECS[i]) run_vec(VECS[i]);

    check(bad_addr == 0, "R3 page address bits", bad_addr, 0);

    // R11: cmd_start during the program cycle is ignored
    wel_in = 1'b1; page_ok = 1'b1;
    @(negedge clk); cmd_start = 1'b1; start_addr = 17'h00005;
    @(negedge clk); cmd_start = 1'b0;
    in_valid = 1'b1; in_data = 8'h77;
    @(negedge clk); in_valid = 1'b0;
    cmd_end = 1'b1; end_aligned = 1'b1;
    @(negedge clk); cmd_end = 1'b0;
    repeat (5) @(negedge clk);
    cmd_start = 1'b1; start_addr = 17'h00009;
    @(negedge clk); cmd_start = 1'b0;
    check(in_ready == 1'b0, "R11 ready after busy start", int'(in_ready), 0);
    while (wip) @(negedge clk);
    @(negedge clk);
    check(in_ready == 1'b0 && !wip, "R11 idle after cycle", int'(in_ready), 0);
    expm[5] = expm[5] & 8'h77;
    check(mem[5] === expm[5], "R6 single byte merge", int'(mem[5]), int'(expm[5]));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule